// File: doc/BRIEF.md
# Alert Response Responder for a Two-Wire Management Bus

This block sits on the slave side of a two-wire management bus and owns an active-low alert line. A local interrupt request marks an alert as pending, and the block holds the alert line low until the bus master has collected the alert. To collect it, the master sends a Start and then a read to the shared alert response address. Every slave that has an alert pending acknowledges and then sends its own 7-bit address. The data line is open-drain, so these responses combine as a wired AND and the lowest address ends up on the line.

The block compares the data line with what it wanted to send, one bit at a time. When it has released the line for a 1 and then sees the line low, it has lost. It drives nothing more for the rest of that byte and keeps its alert asserted, so it can answer the master's next query. When it sends its whole address without losing, it pulses a serviced flag and releases the alert.

Both bus lines are sampled on the system clock and must already be synchronous to it. Edges are found by comparing each sample with the one taken on the previous cycle. There is no data stream at the edge of this block, so every pin is a plain level or pulse and none of them has a valid/ready handshake.

Top module: `smb_alert_responder`

## Requirements
- R1: After reset, the block releases the data line and the alert line, and the serviced flag is 0.
- R2: A cycle with `irq_i` high makes the alert pending, and `alert_drive_low_o` reads 1 from the following cycle. It stays 1 until the block wins a response. A win clears the pending alert, and this clear takes priority over an `irq_i` that arrives in the same cycle.
- R3: A Start is a falling data line while the clock is high. It restarts address reception from any state. A Stop is a rising data line while the clock is high. It returns the block to idle, and an idle block ignores clock pulses until the next Start.
- R4: The block acknowledges by driving the data line low for the 9th clock of the address byte. It does so only when the alert is pending and the address byte is 0x19 (7-bit address 0001100 followed by read bit 1). In every other case it leaves the acknowledge bit released.
- R5: The response byte is `{own_addr_i, 1'b0}`, sent MSB first. The block drives the line low for a 0 bit and releases it for a 1 bit. It releases the line for the 9th clock, which is the master's acknowledge.
- R6: If the block has released the line for a 1 and samples the line low on a rising clock, it has lost. It then drives nothing more in that byte, raises no serviced pulse and keeps the alert asserted, so a repeated query is answered again.
- R7: If the block sends all 8 response bits without losing, `serviced_o` is high for exactly one cycle. The alert is released on the following cycle.
- R8: The data drive output changes only in cycles that follow a sample of the clock line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line (wired level) |
| irq_i | input | 1 | Local interrupt request; high for a cycle makes an alert pending |
| own_addr_i | input | 7 | This slave's 7-bit address, sent in the response |
| sda_drive_low_o | output | 1 | 1 = pull the data line low |
| alert_drive_low_o | output | 1 | 1 = pull the alert line low |
| serviced_o | output | 1 | One-cycle pulse when the response was won |

## Verification
Some properties are checked on every cycle. The data drive may change only after the clock line was low. The block pulls the data line only while its alert is pending. A serviced pulse lasts one cycle, needs a pending alert, and releases the alert on the next cycle. An interrupt request that does not collide with a win raises the alert. Other behaviour can only be shown by whole bus scenarios. These cover the bit-serial response and its wired-AND arbitration against a modelled competitor, over every own address. They also cover retrying after a loss, the acknowledge refused for wrong addresses, for a write and with no alert pending, and recovery through a restarted Start or a Stop.

// File: rtl/smb_alert_pkg.sv
package smb_alert_pkg;
  // Shared 7-bit address answered by every slave with an alert pending
  localparam logic [6:0] ALERT_QUERY_ADDR = 7'b0001100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_SEND,
    ST_MACK,
    ST_SKIP
  } resp_state_e;
endpackage

// File: rtl/smb_line_events.sv
module smb_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // data edges while the clock stays high mark framing conditions
  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
  assign rise_o  = scl_i & ~scl_q;
  assign fall_o  = ~scl_i & scl_q;
endmodule

// File: rtl/smb_alert_pending.sv
module smb_alert_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_i,
  input  logic win_i,
  output logic pending_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pending_o <= 1'b0;
    else if (win_i) pending_o <= 1'b0;   // a win outranks a same-cycle request
    else if (irq_i) pending_o <= 1'b1;
  end
endmodule

// File: rtl/smb_alert_fsm.sv
module smb_alert_fsm
  import smb_alert_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sda_i,
  input  logic              pending_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  output logic              sda_drive_low_o,
  output logic              win_o
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [BYTE_W-1:0] QUERY_BYTE = {BYTE_W'(ALERT_QUERY_ADDR), 1'b0} | BYTE_W'(1);

  resp_state_e       state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              lost;
  logic              win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      lost    <= 1'b0;
      win_q   <= 1'b0;
    end else begin
      win_q <= 1'b0;
      if (start_i) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
      end else if (stop_i) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (rise_i) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_i};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (fall_i && bit_cnt == LAST_BIT) begin
              state <= (pending_i && shreg == QUERY_BYTE) ? ST_ACK : ST_SKIP;
            end
          end
          ST_ACK: begin
            if (fall_i) begin
              state   <= ST_SEND;
              shreg   <= {own_addr_i, 1'b0};
              bit_cnt <= '0;
              lost    <= 1'b0;
            end
          end
          ST_SEND: begin
            if (rise_i) begin
              bit_cnt <= bit_cnt + 1'b1;
              if (shreg[BYTE_W-1] && !sda_i) lost <= 1'b1;
            end else if (fall_i) begin
              shreg <= {shreg[BYTE_W-2:0], 1'b0};
              if (bit_cnt == LAST_BIT) begin
                state <= ST_MACK;
                win_q <= ~lost;
              end
            end
          end
          ST_MACK: if (fall_i) state <= ST_SKIP;
          default: ;
        endcase
      end
    end
  end

  assign sda_drive_low_o = (state == ST_ACK) |
                           ((state == ST_SEND) & ~shreg[BYTE_W-1] & ~lost);
  assign win_o = win_q;
endmodule

// File: rtl/smb_alert_responder.sv
module smb_alert_responder #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              irq_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  output logic              sda_drive_low_o,
  output logic              alert_drive_low_o,
  output logic              serviced_o
);
  logic start_ev, stop_ev, rise_ev, fall_ev;
  logic pending, win;

  smb_line_events u_events (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_i),
    .sda_i  (sda_i),
    .start_o(start_ev),
    .stop_o (stop_ev),
    .rise_o (rise_ev),
    .fall_o (fall_ev)
  );

  smb_alert_pending u_pending (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_i    (irq_i),
    .win_i    (win),
    .pending_o(pending)
  );

  smb_alert_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_ev),
    .stop_i         (stop_ev),
    .rise_i         (rise_ev),
    .fall_i         (fall_ev),
    .sda_i          (sda_i),
    .pending_i      (pending),
    .own_addr_i     (own_addr_i),
    .sda_drive_low_o(sda_drive_low_o),
    .win_o          (win)
  );

  assign alert_drive_low_o = pending;
  assign serviced_o        = win;
endmodule

// File: rtl/smb_alert_responder_chk.sv
module smb_alert_responder_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic irq_i,
  input logic sda_drive_low_o,
  input logic alert_drive_low_o,
  input logic serviced_o
);
  assert_drive_on_low_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_drive_low_o != $past(sda_drive_low_o)) |-> !$past(scl_i));

  assert_drive_needs_alert_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sda_drive_low_o |-> alert_drive_low_o);

  assert_serviced_needs_alert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    serviced_o |-> alert_drive_low_o);

  assert_serviced_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    serviced_o |=> !serviced_o);

  assert_alert_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (serviced_o && !irq_i) |=> !alert_drive_low_o);

  assert_irq_raises_alert_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_i && !serviced_o) |=> alert_drive_low_o);
endmodule

bind smb_alert_responder smb_alert_responder_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .scl_i            (scl_i),
  .irq_i            (irq_i),
  .sda_drive_low_o  (sda_drive_low_o),
  .alert_drive_low_o(alert_drive_low_o),
  .serviced_o       (serviced_o)
);

// File: tb/test_smb_alert_responder.sv
`timescale 1ns/1ps
module test_smb_alert_responder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, comp_drv = 1'b0;
  logic irq = 1'b0;
  logic [6:0] own = 7'h00;
  logic dut_drv, alert, serviced;
  logic sda_line;
  int checks = 0, errors = 0, svc_cnt = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;
  assign sda_line = m_sda & ~dut_drv & ~comp_drv;

  smb_alert_responder i_smb_alert_responder (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .irq_i(irq),
    .own_addr_i(own), .sda_drive_low_o(dut_drv), .alert_drive_low_o(alert),
    .serviced_o(serviced)
  );

  always @(posedge clk) if (serviced) svc_cnt <= svc_cnt + 1;

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(2); m_scl = 1'b1; tick(4); m_sda = 1'b0; tick(4); m_scl = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(4); m_scl = 1'b1; tick(4); m_sda = 1'b1; tick(4);
  endtask

  // master drives a bit; reports the responder's drive seen mid-high
  task automatic send_bit(input logic b, output logic drv);
    m_sda = b; tick(4); m_scl = 1'b1; tick(2); drv = dut_drv; tick(2); m_scl = 1'b0; tick(2);
  endtask

  // master reads a bit; optional competitor responder with its own loss tracking
  task automatic read_bit(input logic cen, input logic cbit, inout logic clost, output logic b);
    m_sda = 1'b1; comp_drv = cen & ~cbit & ~clost; tick(4);
    m_scl = 1'b1; tick(2); b = sda_line;
    if (cen && cbit && !b) clost = 1'b1;
    tick(2); m_scl = 1'b0; tick(1); comp_drv = 1'b0; tick(1);
  endtask

  task automatic query(input logic [7:0] abyte, input logic cen, input logic [6:0] caddr,
                       output logic ack, output logic [7:0] rx, output logic mdrv);
    logic d, cl, b;
    logic [7:0] cb;
    cb = {caddr, 1'b0}; cl = 1'b0; rx = '0; mdrv = 1'b0;
    bus_start();
    for (int i = 7; i >= 0; i--) send_bit(abyte[i], d);
    read_bit(1'b0, 1'b0, cl, ack);
    if (!ack) begin
      for (int i = 7; i >= 0; i--) begin read_bit(cen, cb[i], cl, b); rx[i] = b; end
      send_bit(1'b0, mdrv);
    end
    bus_stop();
  endtask

  task automatic raise_irq();
    irq = 1'b1; tick(1); irq = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack, mdrv, d, cl, b;
    logic [7:0] rx;
    int s0, w, won, c, cpres;
    tick(3);
    check("R1 sda released", dut_drv, 0);
    check("R1 alert released", alert, 0);
    check("R1 serviced low", serviced, 0);
    rst_n = 1'b1; tick(4);
    own = 7'h2A;

    // R4: no alert pending -> acknowledge left released
    query(8'h19, 1'b0, 7'h0, ack, rx, mdrv);
    check("R4 no pending nack", ack, 1);
    raise_irq(); tick(1);
    check("R2 alert after irq", alert, 1);
    query(8'h18, 1'b0, 7'h0, ack, rx, mdrv);
    check("R4 write nack", ack, 1);
    query(8'h1B, 1'b0, 7'h0, ack, rx, mdrv);
    check("R4 other address nack", ack, 1);

    // R3: Stop mid-byte, then clock pulses without Start are ignored
    bus_start();
    for (int i = 0; i < 4; i++) send_bit(1'b0, d);
    bus_stop();
    m_scl = 1'b0; tick(2);
    for (int i = 7; i >= 0; i--) send_bit(i == 4 || i == 3 || i == 0, d);
    cl = 1'b0; read_bit(1'b0, 1'b0, cl, ack);
    check("R3 idle after stop nack", ack, 1);
    bus_stop();

    // R3: repeated Start mid-byte restarts reception
    bus_start();
    for (int i = 0; i < 3; i++) send_bit(1'b1, d);
    m_scl = 1'b0; tick(2);
    query(8'h19, 1'b0, 7'h0, ack, rx, mdrv);
    check("R3 restart then ack", ack, 0);
    check("R5 own byte after restart", rx, 8'h54);
    check("R2 alert cleared after win", alert, 0);

    // sweep every own address against a modelled competitor
    for (int a = 0; a < 128; a++) begin
      own = 7'(a);
      c = (a * 37 + 11) % 128;
      cpres = (a % 3) != 0;
      raise_irq(); tick(1);
      check("R2 alert pending", alert, 1);
      s0 = svc_cnt;
      query(8'h19, cpres[0], 7'(c), ack, rx, mdrv);
      w = (cpres && c < a) ? c : a;
      won = (!cpres || a <= c) ? 1 : 0;
      check("R4 query ack", ack, 0);
      check("R5 R6 response byte", rx, w * 2);
      check("R5 master ack released", mdrv, 0);
      check("R7 serviced pulses", svc_cnt - s0, won);
      check("R6 R7 alert after query", alert, won ? 0 : 1);
      if (!won) begin
        s0 = svc_cnt;
        query(8'h19, 1'b0, 7'h0, ack, rx, mdrv);
        check("R6 repeated query answered", rx, a * 2);
        check("R7 serviced on retry", svc_cnt - s0, 1);
        check("R7 alert released on retry", alert, 0);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule